// File: doc/BRIEF.md
# Stretched-Timing Serial Transmitter

This block sends one byte per frame on an asynchronous serial line whose far end samples each bit late and runs from a slightly slower clock. A frame opens with a low start bit. Eight data bits follow, least significant first. One or two high stop bits close it. The length of one bit in clocks comes from a programmable input.

Three stretch controls adjust the timing without changing that base length. One extends the start bit by a fixed extra amount, 5 clocks by default, so that the late-sampling receiver lines up on the data bits. One adds a single clock to every bit, which lowers the effective rate slightly toward a slower target. One appends a second stop bit.

A frame starts when a send strobe arrives while the block is idle. The data byte and all configuration inputs are captured at that moment. The busy flag covers the whole frame, and strobes that arrive while it is raised are dropped.

Top module: `stretch_serial_tx`

## Requirements
- R1: After reset and whenever no frame is in progress, `line_o` is 1 and `busy_o` is 0.
- R2: A frame is one low start bit, then `DATA_W` data bits with bit 0 first, then the stop bit(s) driven high. Each data bit and each stop bit lasts L clocks, where L is `bit_len_i` plus 1 if `bit_stretch_i` was set.
- R3: With `start_stretch_i` set, the start bit lasts L + `START_EXTRA` clocks (5 by default). Otherwise it lasts L clocks.
- R4: With `bit_stretch_i` set, every bit of the frame, the start bit included, is one clock longer than `bit_len_i`.
- R5: With `two_stop_i` set, a second stop bit of L clocks follows the first. The line is high in the last cycle of every frame.
- R6: `send_i` high while `busy_o` is 0 is accepted at that clock edge. `busy_o` and the low start bit both appear at that same edge. `busy_o` stays high for exactly S + (`DATA_W` + number of stop bits) × L cycles, where S is the start-bit length.
- R7: `send_i` is ignored whenever `busy_o` is 1, including the final cycle of the last stop bit. Such a strobe leaves the running frame unchanged and starts no new frame.
- R8: The data byte and the values of `bit_len_i`, `start_stretch_i`, `bit_stretch_i` and `two_stop_i` are captured at acceptance. Changes to these inputs during a frame do not alter that frame.
- R9: `bit_len_i` must be at least `MIN_LEN` (14) whenever a send is accepted.
- R10: A strobe given in the first cycle after `busy_o` falls is accepted, so frames can follow back to back with no idle cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| send_i | input | 1 | Send strobe; accepted only while idle |
| data_i | input | DATA_W | Byte to send |
| bit_len_i | input | CNT_W | Base bit length in clocks |
| start_stretch_i | input | 1 | Lengthen the start bit by START_EXTRA clocks |
| bit_stretch_i | input | 1 | Add one clock to every bit |
| two_stop_i | input | 1 | Append a second stop bit |
| line_o | output | 1 | Serial line, idles high (registered) |
| busy_o | output | 1 | Frame in progress (registered) |

## Verification
Two functions can coincide in one cycle: the final clock of the last stop bit and a new send strobe. Because `busy_o` is still high in that clock, the strobe must be dropped. The bench raises the strobe exactly in that cycle and then checks that the line stays high and `busy_o` stays low for several cycles. It also raises a strobe in the first idle cycle afterwards and checks that the next start bit begins at once, with the expected waveform traced clock by clock.

// File: rtl/sttx_pkg.sv
package sttx_pkg;
  typedef enum logic [1:0] {
    ST_IDLE  = 2'd0,
    ST_START = 2'd1,
    ST_DATA  = 2'd2,
    ST_STOP  = 2'd3
  } tx_state_e;
endpackage

// File: rtl/sttx_bit_timer.sv
module sttx_bit_timer #(
  parameter int DUR_W = 9
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             load_i,
  input  logic [DUR_W-1:0] load_val_i,
  output logic             expired_o
);
  logic [DUR_W-1:0] cnt_q;

  always_ff @(posedge clk) begin
    if (rst)
      cnt_q <= '0;
    else if (load_i)
      cnt_q <= load_val_i;
    else if (cnt_q != '0)
      cnt_q <= cnt_q - 1'b1;
  end

  assign expired_o = (cnt_q == '0);
endmodule

// File: rtl/sttx_shifter.sv
module sttx_shifter #(
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              load_i,
  input  logic [DATA_W-1:0] data_i,
  input  logic              shift_i,
  output logic              cur_o,
  output logic              next_o
);
  logic [DATA_W-1:0] sh_q;

  always_ff @(posedge clk) begin
    if (rst)
      sh_q <= '0;
    else if (load_i)
      sh_q <= data_i;
    else if (shift_i)
      sh_q <= {1'b0, sh_q[DATA_W-1:1]};
  end

  assign cur_o  = sh_q[0];
  assign next_o = sh_q[1];
endmodule

// File: rtl/sttx_seq.sv
module sttx_seq
  import sttx_pkg::*;
#(
  parameter int DATA_W      = 8,
  parameter int CNT_W       = 8,
  parameter int START_EXTRA = 5
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             send_i,
  input  logic [CNT_W-1:0] bit_len_i,
  input  logic             start_stretch_i,
  input  logic             bit_stretch_i,
  input  logic             two_stop_i,
  input  logic             expired_i,
  input  logic             cur_i,
  input  logic             next_i,
  output logic             timer_load_o,
  output logic [CNT_W:0]   timer_val_o,
  output logic             sh_load_o,
  output logic             sh_shift_o,
  output logic             line_o,
  output logic             busy_o
);
  localparam int DUR_W = CNT_W + 1;
  localparam int IDX_W = (DATA_W > 1) ? $clog2(DATA_W) : 1;
  localparam logic [IDX_W-1:0] LAST_IDX = IDX_W'(DATA_W - 1);

  tx_state_e        state_q;
  logic [IDX_W-1:0] idx_q;
  logic             stop2_pend_q;
  logic [CNT_W-1:0] len_q;
  logic             bs_q;
  logic             line_q;
  logic             busy_q;

  logic             accept;
  logic             step;
  logic [DUR_W-1:0] bit_dur_in;
  logic [DUR_W-1:0] start_dur_in;
  logic [DUR_W-1:0] bit_dur_q;

  assign accept = send_i && (state_q == ST_IDLE) && !busy_q;
  assign step   = (state_q != ST_IDLE) && expired_i;

  assign bit_dur_in   = {1'b0, bit_len_i} + DUR_W'(bit_stretch_i);
  assign start_dur_in = bit_dur_in + (start_stretch_i ? DUR_W'(START_EXTRA) : '0);
  assign bit_dur_q    = {1'b0, len_q} + DUR_W'(bs_q);

  assign timer_load_o = accept || step;
  assign timer_val_o  = accept ? (start_dur_in - 1'b1) : (bit_dur_q - 1'b1);
  assign sh_load_o    = accept;
  assign sh_shift_o   = step && (state_q == ST_DATA) && (idx_q != LAST_IDX);

  always_ff @(posedge clk) begin
    if (rst) begin
      state_q      <= ST_IDLE;
      idx_q        <= '0;
      stop2_pend_q <= 1'b0;
      len_q        <= '0;
      bs_q         <= 1'b0;
      line_q       <= 1'b1;
      busy_q       <= 1'b0;
    end else if (accept) begin
      state_q      <= ST_START;
      idx_q        <= '0;
      stop2_pend_q <= two_stop_i;
      len_q        <= bit_len_i;
      bs_q         <= bit_stretch_i;
      line_q       <= 1'b0;
      busy_q       <= 1'b1;
    end else if (step) begin
      unique case (state_q)
        ST_START: begin
          state_q <= ST_DATA;
          line_q  <= cur_i;
        end
        ST_DATA: begin
          if (idx_q == LAST_IDX) begin
            state_q <= ST_STOP;
            line_q  <= 1'b1;
          end else begin
            idx_q  <= idx_q + 1'b1;
            line_q <= next_i;
          end
        end
        ST_STOP: begin
          if (stop2_pend_q) begin
            stop2_pend_q <= 1'b0;
          end else begin
            state_q <= ST_IDLE;
            busy_q  <= 1'b0;
          end
          line_q <= 1'b1;
        end
        default: begin
          state_q <= ST_IDLE;
          busy_q  <= 1'b0;
          line_q  <= 1'b1;
        end
      endcase
    end
  end

  assign line_o = line_q;
  assign busy_o = busy_q;
endmodule

// File: rtl/stretch_serial_tx.sv
module stretch_serial_tx #(
  parameter int DATA_W      = 8,
  parameter int CNT_W       = 8,
  parameter int START_EXTRA = 5,
  parameter int MIN_LEN     = 14
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              send_i,
  input  logic [DATA_W-1:0] data_i,
  input  logic [CNT_W-1:0]  bit_len_i,
  input  logic              start_stretch_i,
  input  logic              bit_stretch_i,
  input  logic              two_stop_i,
  output logic              line_o,
  output logic              busy_o
);
  localparam int DUR_W = CNT_W + 1;

  logic             timer_load;
  logic [DUR_W-1:0] timer_val;
  logic             expired;
  logic             sh_load;
  logic             sh_shift;
  logic             cur_bit;
  logic             next_bit;

  sttx_bit_timer #(.DUR_W(DUR_W)) u_timer (
    .clk        (clk),
    .rst        (rst),
    .load_i     (timer_load),
    .load_val_i (timer_val),
    .expired_o  (expired)
  );

  sttx_shifter #(.DATA_W(DATA_W)) u_shift (
    .clk     (clk),
    .rst     (rst),
    .load_i  (sh_load),
    .data_i  (data_i),
    .shift_i (sh_shift),
    .cur_o   (cur_bit),
    .next_o  (next_bit)
  );

  sttx_seq #(
    .DATA_W      (DATA_W),
    .CNT_W       (CNT_W),
    .START_EXTRA (START_EXTRA)
  ) u_seq (
    .clk             (clk),
    .rst             (rst),
    .send_i          (send_i),
    .bit_len_i       (bit_len_i),
    .start_stretch_i (start_stretch_i),
    .bit_stretch_i   (bit_stretch_i),
    .two_stop_i      (two_stop_i),
    .expired_i       (expired),
    .cur_i           (cur_bit),
    .next_i          (next_bit),
    .timer_load_o    (timer_load),
    .timer_val_o     (timer_val),
    .sh_load_o       (sh_load),
    .sh_shift_o      (sh_shift),
    .line_o          (line_o),
    .busy_o          (busy_o)
  );
endmodule

// File: rtl/sttx_checker.sv
module sttx_checker #(
  parameter int CNT_W   = 8,
  parameter int MIN_LEN = 14
) (
  input logic             clk,
  input logic             rst,
  input logic             send_i,
  input logic [CNT_W-1:0] bit_len_i,
  input logic             line_o,
  input logic             busy_o
);
  AST_IDLE_HIGH: assert property (@(posedge clk) disable iff (rst)
    !busy_o |-> line_o);                                  // R1

  AST_START_LOW: assert property (@(posedge clk) disable iff (rst)
    $rose(busy_o) |-> !line_o);                           // R2

  AST_ACCEPT_IDLE: assert property (@(posedge clk) disable iff (rst)
    (!busy_o && send_i) |=> (busy_o && !line_o));         // R6

  AST_BUSY_HOLDS: assert property (@(posedge clk) disable iff (rst)
    $rose(busy_o) |=> busy_o);                            // R6

  AST_END_HIGH: assert property (@(posedge clk) disable iff (rst)
    $fell(busy_o) |-> ($past(line_o) && line_o));         // R5

  AST_LEN_MIN: assert property (@(posedge clk) disable iff (rst)
    (!busy_o && send_i) |-> (int'(bit_len_i) >= MIN_LEN)); // R9
endmodule

bind stretch_serial_tx sttx_checker #(.CNT_W(CNT_W), .MIN_LEN(MIN_LEN)) u_chk (
  .clk       (clk),
  .rst       (rst),
  .send_i    (send_i),
  .bit_len_i (bit_len_i),
  .line_o    (line_o),
  .busy_o    (busy_o)
);

// File: tb/test_stretch_serial_tx.sv
`timescale 1ns/1ps
module test_stretch_serial_tx;
  localparam int DATA_W = 8;
  localparam int CNT_W  = 8;
  localparam int EXTRA  = 5;

  logic              clk = 1'b0;
  logic              rst = 1'b1;
  logic              send_i = 1'b0;
  logic [DATA_W-1:0] data_i = '0;
  logic [CNT_W-1:0]  bit_len_i = 8'd14;
  logic              start_stretch_i = 1'b0;
  logic              bit_stretch_i = 1'b0;
  logic              two_stop_i = 1'b0;
  logic              line_o;
  logic              busy_o;

  int n_checks = 0;
  int n_fails  = 0;

  always #10 clk = ~clk;

  stretch_serial_tx #(.DATA_W(DATA_W), .CNT_W(CNT_W), .START_EXTRA(EXTRA)) i_stretch_serial_tx (
    .clk(clk), .rst(rst), .send_i(send_i), .data_i(data_i), .bit_len_i(bit_len_i),
    .start_stretch_i(start_stretch_i), .bit_stretch_i(bit_stretch_i),
    .two_stop_i(two_stop_i), .line_o(line_o), .busy_o(busy_o)
  );

  task automatic check(input bit ok, input string req, input int act, input int exp);
    n_checks++;
    if (!ok) begin
      n_fails++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  // Drive a frame request; caller is at a negedge.
  task automatic drive(input logic [7:0] d, input int len, input bit ss, input bit bs, input bit ts);
    send_i = 1'b1; data_i = d; bit_len_i = CNT_W'(len);
    start_stretch_i = ss; bit_stretch_i = bs; two_stop_i = ts;
  endtask

  // mode 0: plain; 1: strobe and config change mid-frame; 2: strobe in last busy cycle;
  // 3: chain a second frame (cd) in the first idle cycle. pre: request already driven.
  task automatic run_frame(input logic [7:0] d, input int len, input bit ss, input bit bs,
                           input bit ts, input int mode, input bit pre, input string req,
                           input logic [7:0] cd);
    int L, S, T, bad_line, bad_busy, first_k, first_act, first_exp;
    logic e;
    L = len + (bs ? 1 : 0);
    S = L + (ss ? EXTRA : 0);
    T = S + (DATA_W + (ts ? 2 : 1)) * L;
    bad_line = 0; bad_busy = 0; first_k = -1; first_act = 0; first_exp = 0;
    if (!pre) begin
      @(negedge clk);
      drive(d, len, ss, bs, ts);
    end
    @(negedge clk);
    send_i = 1'b0;
    for (int k = 0; k <= T; k++) begin
      if (k < S) e = 1'b0;
      else if (k < S + DATA_W * L) e = d[(k - S) / L];
      else e = 1'b1;
      if (line_o !== e) begin
        bad_line++;
        if (first_k < 0) begin first_k = k; first_act = int'(line_o); first_exp = int'(e); end
      end
      if (busy_o !== (k < T)) bad_busy++;
      if (mode == 1 && k == 20) begin
        drive(~d, len + 3, ~ss, ~bs, ~ts);
      end else if (mode == 1 && k == 21) begin
        send_i = 1'b0;
      end else if (mode == 2 && k == T - 1) begin
        drive(~d, len, ss, bs, ts);
      end else if (mode == 2 && k == T) begin
        send_i = 1'b0;
      end else if (mode == 3 && k == T) begin
        drive(cd, len, ss, bs, ts);
      end
      if (k < T) @(negedge clk);
    end
    check(bad_line == 0, {req, " line waveform"}, first_act, first_exp);
    if (bad_line != 0) $display("  first mismatch at cycle %0d", first_k);
    check(bad_busy == 0, {req, " busy window R6"}, bad_busy, 0);
    if (mode != 3) begin
      bad_line = 0;
      for (int j = 0; j < 4; j++) begin
        @(negedge clk);
        if (line_o !== 1'b1 || busy_o !== 1'b0) bad_line++;
      end
      check(bad_line == 0, {req, " idle after frame R1 R7"}, bad_line, 0);
    end
  endtask

  task automatic t_reset();
    repeat (3) @(negedge clk);
    check(line_o === 1'b1 && busy_o === 1'b0, "R1 reset state", int'({line_o, busy_o}), 2);
    rst = 1'b0;
    @(negedge clk);
    check(line_o === 1'b1 && busy_o === 1'b0, "R1 idle after reset", int'({line_o, busy_o}), 2);
  endtask

  task automatic t_plain();      run_frame(8'hA5, 14, 0, 0, 0, 0, 0, "R2 plain", 8'h00); endtask
  task automatic t_start_st();   run_frame(8'h3C, 14, 1, 0, 0, 0, 0, "R3 start stretch", 8'h00); endtask
  task automatic t_bit_st();     run_frame(8'h81, 16, 0, 1, 0, 0, 0, "R4 bit stretch", 8'h00); endtask
  task automatic t_two_stop();   run_frame(8'hFF, 15, 1, 1, 1, 0, 0, "R5 two stop", 8'h00); endtask
  task automatic t_latch();      run_frame(8'h5A, 14, 0, 0, 0, 1, 0, "R7 R8 mid-frame change", 8'h00); endtask
  task automatic t_last_cycle(); run_frame(8'h00, 14, 1, 0, 1, 2, 0, "R7 strobe in last cycle", 8'h00); endtask
  task automatic t_chain();
    run_frame(8'h96, 14, 0, 1, 0, 3, 0, "R10 first of pair", 8'h69);
    run_frame(8'h69, 14, 0, 1, 0, 0, 1, "R10 back to back", 8'h00);
  endtask

  initial begin
    t_reset();
    t_plain();
    t_start_st();
    t_bit_st();
    t_two_stop();
    t_latch();
    t_last_cycle();
    t_chain();
    $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fails);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    n_checks++;
    n_fails++;
    $display("FAIL watchdog expired R6 actual=%0d expected=%0d", 1, 0);
    $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fails);
    $finish;
  end
endmodule